// File: doc/BRIEF.md
# Sample-Offset Word Aligner

The aligner sits between a sample FIFO and a display renderer. Each 64-bit input word carries eight 8-bit ADC samples, and byte 0 is the oldest sample. The aligner re-emits a record so that its first output byte is a chosen sample. The renderer can then move a trace left by whole samples without touching sample memory.

A 5-bit offset is latched by a start strobe at the head of each record, and it splits into two parts.

- **Coarse part:** drops up to three whole leading words. These words are popped from the FIFO and never shown.
- **Fine part:** picks an eight-byte window out of two adjacent words placed side by side.

A flag on the last FIFO word closes the record. When the window is shifted, one extra output word drains the bytes still held, and its empty upper lanes are padded with zero.

The input is a show-ahead FIFO read port: data is valid whenever the FIFO is not empty, and a read strobe pops it. The output is a valid/ready stream carrying a last-word flag.

Top module: `sample_aligner`

## Requirements
- R1: On a cycle with `start_i` high, `offset_i` is latched. Bits [4:3] give the discard count D, and bits [2:0] give the byte shift S. Changes on `offset_i` at any other time have no effect until the next strobe.
- R2: The first D words of a record are popped and dropped. None of their bytes appears at the output, and `out_valid_o` stays low while they are dropped.
- R3: For S other than 0, output lane k (bits [8k+7:8k]) equals byte k+S of the 128-bit value {next word, current word}. Byte 0 is bits [7:0] of the current word.
- R4: For S equal to 0, output words equal input words unchanged. Every accepted output word is popped in the same cycle it is accepted, so no input word is held back.
- R5: `fifo_last_i` marks the final word of a record, and a record of N words yields N-D output words. With S other than 0, the last output word is a flush of the held word: lanes at and beyond 8-S are zero and no pop occurs. `out_last_o` flags the final output word.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the output data and last flag hold steady. The FIFO is never popped in a cycle where a valid output is not accepted.
- R7: `fifo_rd_o` is never high while `fifo_empty_i` is high.
- R8: If the record's last word falls inside the discard phase, no output is produced and the block returns to idle.
- R9: After reset, and after the final output word of a record is accepted, `out_valid_o` and `fifo_rd_o` stay low until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-record strobe, latches offset |
| offset_i | input | 5 | {discard words[1:0], byte shift[2:0]} |
| fifo_empty_i | input | 1 | Input FIFO has no word |
| fifo_data_i | input | 64 | Head word of the FIFO (show-ahead) |
| fifo_last_i | input | 1 | Head word is the last of the record |
| fifo_rd_o | output | 1 | Pop the head word |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the output word |
| out_data_o | output | 64 | Aligned eight-sample word |
| out_last_o | output | 1 | Final word of the aligned record |

## Verification
The difficult overlap is backpressure arriving in the same cycle the record ends. This happens either on the final popped word or on the flush word that follows it. If a stall hits then, the held word must not be overwritten, and the flush must not be skipped or repeated.

To provoke this, the bench drives ready with a pattern that is mostly low while records of every offset finish. It also inserts gaps into FIFO delivery.

To judge the result, the scoreboard compares each accepted word, its last flag, and whether a pop occurred in that cycle. It then confirms that the FIFO drained and that the output went quiet.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_FILL,
    ST_RUN,
    ST_FLUSH
  } state_e;
endpackage

// File: rtl/aligner_ctrl.sv
module aligner_ctrl #(
  parameter int SKIP_W  = 2,
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SKIP_W-1:0]  skip_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               fifo_empty_i,
  input  logic               fifo_last_i,
  input  logic               out_ready_i,
  output logic               fifo_rd_o,
  output logic               out_valid_o,
  output logic               out_last_o,
  output logic               hold_load_o,
  output logic               flush_o,
  output logic               bypass_o,
  output logic [SHIFT_W-1:0] shift_o
);
  import aligner_pkg::*;

  state_e             state_q, state_d;
  logic [SKIP_W-1:0]  skip_q, skip_d;
  logic [SHIFT_W-1:0] shift_q;
  logic               bypass;

  assign bypass   = (shift_q == '0);
  assign bypass_o = bypass;
  assign shift_o  = shift_q;

  always_comb begin
    state_d     = state_q;
    skip_d      = skip_q;
    fifo_rd_o   = 1'b0;
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    hold_load_o = 1'b0;
    flush_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: ;
      ST_SKIP: begin
        fifo_rd_o = !fifo_empty_i;
        if (fifo_rd_o) begin
          skip_d = skip_q - SKIP_W'(1);
          if (fifo_last_i)                state_d = ST_IDLE;
          else if (skip_q == SKIP_W'(1))  state_d = bypass ? ST_RUN : ST_FILL;
        end
      end
      ST_FILL: begin
        fifo_rd_o   = !fifo_empty_i;
        hold_load_o = fifo_rd_o;
        if (fifo_rd_o) state_d = fifo_last_i ? ST_FLUSH : ST_RUN;
      end
      ST_RUN: begin
        out_valid_o = !fifo_empty_i;
        out_last_o  = bypass && fifo_last_i && !fifo_empty_i;
        fifo_rd_o   = !fifo_empty_i && out_ready_i;
        hold_load_o = fifo_rd_o && !bypass;
        if (fifo_rd_o && fifo_last_i) state_d = bypass ? ST_IDLE : ST_FLUSH;
      end
      ST_FLUSH: begin
        out_valid_o = 1'b1;
        out_last_o  = 1'b1;
        flush_o     = 1'b1;
        if (out_ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    // a new strobe restarts the record from any state
    if (start_i) begin
      skip_d = skip_i;
      if (skip_i != '0)       state_d = ST_SKIP;
      else if (shift_i != '0) state_d = ST_FILL;
      else                    state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      skip_q  <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
      if (start_i) shift_q <= shift_i;
    end
  end
endmodule

// File: rtl/aligner_hold.sv
module aligner_hold #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/aligner_window.sv
module aligner_window #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8
) (
  input  logic [SAMPLE_W*LANES-1:0]   lo_i,
  input  logic [SAMPLE_W*LANES-1:0]   hi_i,
  input  logic [$clog2(LANES)-1:0]    shift_i,
  output logic [SAMPLE_W*LANES-1:0]   data_o
);
  localparam int DATA_W  = SAMPLE_W * LANES;
  localparam int SHIFT_W = $clog2(LANES);

  logic [2*DATA_W-1:0] cat;
  assign cat = {hi_i, lo_i};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SAMPLE_W-1:0] lane;
    always_comb begin
      lane = '0;
      for (int s = 0; s < LANES; s++) begin
        if (shift_i == SHIFT_W'(s)) lane = cat[(k+s)*SAMPLE_W +: SAMPLE_W];
      end
    end
    assign data_o[k*SAMPLE_W +: SAMPLE_W] = lane;
  end
endmodule

// File: rtl/sample_aligner.sv
module sample_aligner #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8,
  parameter int SKIP_W   = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic [SKIP_W+$clog2(LANES)-1:0]     offset_i,
  input  logic                                fifo_empty_i,
  input  logic [SAMPLE_W*LANES-1:0]           fifo_data_i,
  input  logic                                fifo_last_i,
  output logic                                fifo_rd_o,
  output logic                                out_valid_o,
  input  logic                                out_ready_i,
  output logic [SAMPLE_W*LANES-1:0]           out_data_o,
  output logic                                out_last_o
);
  localparam int DATA_W  = SAMPLE_W * LANES;
  localparam int SHIFT_W = $clog2(LANES);
  localparam int OFF_W   = SKIP_W + SHIFT_W;

  logic               hold_load, flush, bypass;
  logic [SHIFT_W-1:0] shift;
  logic [DATA_W-1:0]  hold_q, win_hi, win_data;

  aligner_ctrl #(.SKIP_W(SKIP_W), .SHIFT_W(SHIFT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .skip_i      (offset_i[OFF_W-1:SHIFT_W]),
    .shift_i     (offset_i[SHIFT_W-1:0]),
    .fifo_empty_i(fifo_empty_i),
    .fifo_last_i (fifo_last_i),
    .out_ready_i (out_ready_i),
    .fifo_rd_o   (fifo_rd_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .hold_load_o (hold_load),
    .flush_o     (flush),
    .bypass_o    (bypass),
    .shift_o     (shift)
  );

  aligner_hold #(.WIDTH(DATA_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(hold_load),
    .d_i   (fifo_data_i),
    .q_o   (hold_q)
  );

  // flush drains the held word against zero padding
  assign win_hi = flush ? '0 : fifo_data_i;

  aligner_window #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_win (
    .lo_i   (hold_q),
    .hi_i   (win_hi),
    .shift_i(shift),
    .data_o (win_data)
  );

  assign out_data_o = bypass ? fifo_data_i : win_data;
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              fifo_empty_i,
  input logic              fifo_rd_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_last_o
);
  // R6: stalled output holds steady
  a_r6_stall_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !start_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)))
    else $error("a_r6_stall_stable");

  // R6: no pop while a valid word is refused
  a_r6_no_pop_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o && out_valid_o) |-> out_ready_i)
    else $error("a_r6_no_pop_on_stall");

  // R7: never read an empty FIFO
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i)
    else $error("a_r7_no_underflow");

  // R9: quiet after the final word is taken
  a_r9_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o && !start_i) |=>
      (!out_valid_o && !fifo_rd_o))
    else $error("a_r9_idle_after_last");
endmodule

bind sample_aligner aligner_checker #(.DATA_W(SAMPLE_W*LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_rd_o   (fifo_rd_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/sample_aligner_tb.sv
`timescale 1ns/1ps
module sample_aligner_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0]  offset = '0;
  logic        fifo_empty = 1'b1, fifo_last = 1'b0, out_ready = 1'b0;
  logic [63:0] fifo_data = '0;
  logic        fifo_rd, out_valid, out_last;
  logic [63:0] out_data;

  typedef struct packed { logic last; logic [63:0] data; } word_t;
  typedef struct packed { logic byp; logic last; logic pop; logic [63:0] data; } exp_t;

  word_t fq[$];
  word_t pend[$];
  exp_t  eq[$];
  int    n_chk = 0, n_bad = 0, ready_mode = 0, cyc = 0;
  bit    popped = 1'b0;

  always #2.5 clk = ~clk;

  sample_aligner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .offset_i(offset),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_last_i(fifo_last),
    .fifo_rd_o(fifo_rd), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // FIFO model, ready pattern and scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (popped && fq.size() > 0) void'(fq.pop_front());
    popped = 1'b0;
    while (pend.size() > 0) fq.push_back(pend.pop_front());
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 64'h0 : fq[0].data;
    fifo_last  = fifo_empty ? 1'b0  : fq[0].last;
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom_range(0, 1) == 1);
      default: out_ready = ($urandom_range(0, 3) == 0);
    endcase
    #1;
    if (rst_n) begin
      popped = fifo_rd;
      if (fifo_rd) check(!fifo_empty, "R7 pop on empty", 64'(fifo_rd), 64'(0));
      if (out_valid && !out_ready) check(!fifo_rd, "R6 pop while stalled", 64'(fifo_rd), 64'(0));
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          check(1'b0, "R2/R5 unexpected output word", out_data, 64'h0);
        end else begin
          e = eq.pop_front();
          check(out_data === e.data, e.byp ? "R4 passthrough data" : "R3 window data", out_data, e.data);
          check(out_last === e.last, "R5 last flag", 64'(out_last), 64'(e.last));
          check(fifo_rd === e.pop, "R4/R5 pop with output", 64'(fifo_rd), 64'(e.pop));
        end
      end
    end
  end

  task automatic run_record(input logic [4:0] off, input int n, input int gap_max, input int rmode);
    word_t     w[32];
    logic [7:0] bt[256];
    int        d, s, m, idx, wait_cyc;
    exp_t      e;
    d = int'(off[4:3]);
    s = int'(off[2:0]);
    for (int i = 0; i < n; i++) begin
      w[i].data = {$urandom(), $urandom()};
      w[i].last = (i == n - 1);
    end
    m = (n > d) ? n - d : 0;
    for (int i = 0; i < m; i++)
      for (int b = 0; b < 8; b++) bt[i*8+b] = w[d+i].data[b*8 +: 8];
    for (int j = 0; j < m; j++) begin
      e.byp  = (s == 0);
      e.last = (j == m - 1);
      e.pop  = (s == 0) || (j != m - 1);
      for (int k = 0; k < 8; k++) begin
        idx = j*8 + k + s;
        e.data[k*8 +: 8] = (idx < m*8) ? bt[idx] : 8'h00;
      end
      eq.push_back(e);
    end
    ready_mode = rmode;
    @(negedge clk);
    offset = off;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    offset = ~off;  // R1: must be ignored
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, gap_max)) @(posedge clk);
      @(posedge clk);
      pend.push_back(w[i]);
    end
    wait_cyc = 0;
    while ((eq.size() > 0 || fq.size() > 0 || pend.size() > 0) && wait_cyc < 2000) begin
      @(posedge clk);
      wait_cyc++;
    end
    check(eq.size() == 0, "R5 missing output words", 64'(eq.size()), 64'(0));
    check(fq.size() == 0, "R2/R8 FIFO not drained", 64'(fq.size()), 64'(0));
    eq.delete();
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !fifo_rd, "R9 idle after record", {62'(0), out_valid, fifo_rd}, 64'(0));
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !fifo_rd, "R9 reset state", {62'(0), out_valid, fifo_rd}, 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(!out_valid && !fifo_rd, "R9 idle before start", {62'(0), out_valid, fifo_rd}, 64'(0));

    run_record(5'b00_000, 5, 0, 0);   // R4
    run_record(5'b00_011, 6, 0, 0);   // R3
    run_record(5'b01_101, 7, 2, 1);   // R1 R2 R3
    run_record(5'b11_111, 10, 3, 1);  // R2 R3 R5
    run_record(5'b10_000, 4, 1, 2);   // R2 R4 R6
    run_record(5'b11_010, 2, 1, 1);   // R8
    run_record(5'b01_000, 1, 0, 0);   // R8 edge
    run_record(5'b00_001, 1, 0, 2);   // R5 single word flush under stall
    run_record(5'b00_000, 1, 0, 2);   // R4 single word
    for (int o = 0; o < 32; o++) begin
      run_record(5'(o), 3 + (o % 5), o % 3, 1 + (o % 2));  // R1 R3 R6
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule